// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Edge/Level Sensing

This block holds the pending-request bits for one eight-input interrupt controller. Every clock cycle it samples the raw request lines. A trigger-mode register selects how each line is sensed. A level-sensed line drives its request bit directly. An edge-sensed line sets its bit on a low-to-high transition and keeps it set until the line is acknowledged. A per-line record of the last sampled level provides the edge detection.

Downstream logic sees the request bits only after masking. It consumes the masked vector to resolve priority. It reports the line it serves back through an acknowledge strobe carrying a line number. A reinitialise strobe discards stale edge requests and leaves the level-driven state alone. The trigger-mode register takes writes through a fixed writable mask. Lines outside that mask stay edge-sensed. The default mask suits the primary controller (lines 3..7 writable); a secondary controller would use 0xDE.

Top module: `irq_req_latch`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) has its request bit equal to the line level sampled at the previous clock edge, regardless of acknowledge or reinitialise.
- R2: A line whose trigger-mode bit is 0 (edge) sets its request bit at the clock edge where the line is sampled high and the previous-level record for it is low.
- R3: An edge-sensed request bit stays set after its line returns low, for as long as no acknowledge or reinitialise reaches it.
- R4: An acknowledge (ackValid with ackLine = n) clears request bit n only when line n is edge-sensed. A level-sensed bit is unaffected. If a new rising edge arrives on the same line in the same cycle, the bit ends up set.
- R5: A trigger-mode write stores trigWrData AND the WRITABLE parameter (default 0xF8). Bits outside WRITABLE always read 0 (edge), and trigMode shows the stored value from the next cycle on.
- R6: Reinitialise clears every edge-sensed request bit and the whole previous-level record, and leaves trigger-mode unchanged. A line still held high is therefore seen as a fresh edge one cycle later.
- R7: reqMasked equals the request bits AND NOT maskReg, combinationally; a mask bit of 1 hides that line's request.
- R8: While rstN is low, all request bits, the previous-level record and trigger-mode are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineLevel | input | 8 | Raw request line levels, sampled each cycle |
| trigWrEn | input | 1 | Write strobe for the trigger-mode register |
| trigWrData | input | 8 | Trigger-mode write data, 1 = level, 0 = edge |
| ackValid | input | 1 | Acknowledge strobe |
| ackLine | input | 3 | Line number being acknowledged |
| reinit | input | 1 | Reinitialise strobe |
| maskReg | input | 8 | Mask register value, 1 hides a line |
| trigMode | output | 8 | Current trigger-mode register |
| reqMasked | output | 8 | Request bits after masking |

## Verification
The properties assume the input lines are already synchronous to clk. They also assume that in each cycle the mode used for a line is the trigger-mode value held before any write in that same cycle. The stimulus changes every input only at the falling clock edge, so each rising edge samples one stable set of inputs. Acknowledge, reinitialise and mode writes are asserted for exactly one cycle apiece, with the same-cycle collisions of rise and acknowledge applied on purpose.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int LINES = 8;
  localparam int LINE_IDX_W = $clog2(LINES);

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic             trigWr;
    logic [LINES-1:0] ackHot;
    logic             reinit;
  } latch_strb_t;
endpackage

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
(
  input  logic                  trigWrEn,
  input  logic                  ackValid,
  input  logic [LINE_IDX_W-1:0] ackLine,
  input  logic                  reinit,
  output latch_strb_t           strb
);
  logic [LINES-1:0] ackDecode;

  // One-hot decode of the acknowledged line number.
  for (genvar gi = 0; gi < LINES; gi++) begin : g_ack
    assign ackDecode[gi] = ackValid && (ackLine == LINE_IDX_W'(gi));
  end

  always_comb begin
    strb.trigWr = trigWrEn;
    strb.ackHot = ackDecode;
    strb.reinit = reinit;
  end
endmodule

// File: rtl/irq_latch_dp.sv
module irq_latch_dp
  import irq_latch_pkg::*;
#(
  parameter logic [LINES-1:0] WRITABLE = 8'hF8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineLevel,
  input  logic [LINES-1:0] trigWrData,
  input  latch_strb_t      strb,
  output logic [LINES-1:0] trigQ,
  output logic [LINES-1:0] reqQ,
  output logic [LINES-1:0] prevQ
);
  // Trigger-mode register; read-only bits forced to edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigQ <= '0;
    end else if (strb.trigWr) begin
      trigQ <= trigWrData & WRITABLE;
    end
  end

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    logic riseSeen;
    assign riseSeen = lineLevel[gi] && !prevQ[gi];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevQ[gi] <= 1'b0;
        reqQ[gi]  <= 1'b0;
      end else begin
        prevQ[gi] <= strb.reinit ? 1'b0 : lineLevel[gi];
        if (trigQ[gi]) begin
          reqQ[gi] <= lineLevel[gi];
        end else if (strb.reinit) begin
          reqQ[gi] <= 1'b0;
        end else if (riseSeen) begin
          reqQ[gi] <= 1'b1;
        end else if (strb.ackHot[gi]) begin
          reqQ[gi] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter logic [LINES-1:0] WRITABLE = 8'hF8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINES-1:0]      lineLevel,
  input  logic                  trigWrEn,
  input  logic [LINES-1:0]      trigWrData,
  input  logic                  ackValid,
  input  logic [LINE_IDX_W-1:0] ackLine,
  input  logic                  reinit,
  input  logic [LINES-1:0]      maskReg,
  output logic [LINES-1:0]      trigMode,
  output logic [LINES-1:0]      reqMasked
);
  latch_strb_t      strb;
  logic [LINES-1:0] reqRaw;
  logic [LINES-1:0] prevLevel;

  irq_latch_ctrl u_ctrl (
    .trigWrEn (trigWrEn),
    .ackValid (ackValid),
    .ackLine  (ackLine),
    .reinit   (reinit),
    .strb     (strb)
  );

  irq_latch_dp #(.WRITABLE(WRITABLE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineLevel  (lineLevel),
    .trigWrData (trigWrData),
    .strb       (strb),
    .trigQ      (trigMode),
    .reqQ       (reqRaw),
    .prevQ      (prevLevel)
  );

  assign reqMasked = reqRaw & ~maskReg;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk
  import irq_latch_pkg::*;
#(
  parameter logic [LINES-1:0] WRITABLE = 8'hF8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [LINES-1:0]      lineLevel,
  input logic                  trigWrEn,
  input logic [LINES-1:0]      trigWrData,
  input logic                  ackValid,
  input logic [LINE_IDX_W-1:0] ackLine,
  input logic                  reinit,
  input logic [LINES-1:0]      trigMode,
  input logic [LINES-1:0]      reqRaw,
  input logic [LINES-1:0]      prevLevel
);
  logic [LINES-1:0] edgeRise;
  logic [LINES-1:0] ackBits;
  logic [LINES-1:0] holdBits;

  assign edgeRise = lineLevel & ~prevLevel & ~trigMode;
  assign ackBits  = ackValid ? (LINES'(1) << ackLine) : '0;
  assign holdBits = ~trigMode & ~edgeRise & ~ackBits & {LINES{!reinit}};

  assert_level_follow_R1: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((reqRaw & $past(trigMode)) == ($past(lineLevel) & $past(trigMode))));

  assert_edge_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeRise != '0) && !reinit) |=> ((reqRaw & $past(edgeRise)) == $past(edgeRise)));

  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((reqRaw & $past(holdBits)) == ($past(reqRaw) & $past(holdBits))));

  assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !trigMode[ackLine] && !edgeRise[ackLine] && !reinit)
      |=> !reqRaw[$past(ackLine)]);

  assert_trig_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    trigWrEn |=> (trigMode == ($past(trigWrData) & WRITABLE)));

  assert_trig_readonly_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode & ~WRITABLE) == '0);

  assert_reinit_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    reinit |=> (((reqRaw & ~$past(trigMode)) == '0) && (prevLevel == '0)));

  assert_reinit_keep_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reinit && !trigWrEn) |=> $stable(trigMode));
endmodule

bind irq_req_latch irq_req_latch_chk #(.WRITABLE(WRITABLE)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lineLevel  (lineLevel),
  .trigWrEn   (trigWrEn),
  .trigWrData (trigWrData),
  .ackValid   (ackValid),
  .ackLine    (ackLine),
  .reinit     (reinit),
  .trigMode   (trigMode),
  .reqRaw     (reqRaw),
  .prevLevel  (prevLevel)
);

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] lineLevel;
  logic       trigWrEn;
  logic [7:0] trigWrData;
  logic       ackValid;
  logic [2:0] ackLine;
  logic       reinit;
  logic [7:0] maskReg;
  logic [7:0] trigMode;
  logic [7:0] reqMasked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_req_latch u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .lineLevel  (lineLevel),
    .trigWrEn   (trigWrEn),
    .trigWrData (trigWrData),
    .ackValid   (ackValid),
    .ackLine    (ackLine),
    .reinit     (reinit),
    .maskReg    (maskReg),
    .trigMode   (trigMode),
    .reqMasked  (reqMasked)
  );

  // {wr, wdata, lines, ack, ackLine, reinit, mask, expReq, expTrig}
  localparam int NVEC = 18;
  localparam logic [45:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00}, // idle
    {1'b0, 8'h00, 8'h01, 1'b0, 3'd0, 1'b0, 8'h00, 8'h01, 8'h00}, // R2 rise line0
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h01, 8'h00}, // R3 fall keeps
    {1'b0, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00}, // R4 ack edge
    {1'b1, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 8'hF8}, // R5 write FF
    {1'b0, 8'h00, 8'h18, 1'b0, 3'd0, 1'b0, 8'h00, 8'h18, 8'hF8}, // R1 level high
    {1'b0, 8'h00, 8'h18, 1'b1, 3'd3, 1'b0, 8'h00, 8'h18, 8'hF8}, // R4 ack level
    {1'b0, 8'h00, 8'h10, 1'b0, 3'd0, 1'b0, 8'h00, 8'h10, 8'hF8}, // R1 level low
    {1'b0, 8'h00, 8'h11, 1'b0, 3'd0, 1'b0, 8'h01, 8'h10, 8'hF8}, // R7 mask line0
    {1'b0, 8'h00, 8'h11, 1'b0, 3'd0, 1'b1, 8'h00, 8'h10, 8'hF8}, // R6 reinit
    {1'b0, 8'h00, 8'h11, 1'b0, 3'd0, 1'b0, 8'h00, 8'h11, 8'hF8}, // R6 re-edge
    {1'b0, 8'h00, 8'h13, 1'b1, 3'd1, 1'b0, 8'h00, 8'h13, 8'hF8}, // R4 rise wins
    {1'b0, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 8'h00, 8'h02, 8'hF8}, // R3 R4 mixed
    {1'b1, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h02, 8'h00}, // R5 write 00
    {1'b0, 8'h00, 8'h80, 1'b0, 3'd0, 1'b0, 8'h00, 8'h82, 8'h00}, // R2 line7 edge
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'hFF, 8'h00, 8'h00}, // R7 mask all
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 8'h00, 8'h00, 8'h00}, // R6 clear edges
    {1'b1, 8'h07, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00}  // R5 read-only
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    lineLevel  = 8'h00;
    trigWrEn   = 1'b0;
    trigWrData = 8'h00;
    ackValid   = 1'b0;
    ackLine    = 3'd0;
    reinit     = 1'b0;
    maskReg    = 8'h00;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    idleInputs();
    repeat (3) @(negedge clk);
    check("R8 reset req", reqMasked, 8'h00);
    check("R8 reset trig", trigMode, 8'h00);
    rstN = 1'b1;

    for (int vi = 0; vi < NVEC; vi++) begin
      logic [45:0] v;
      v = VEC[vi];
      {trigWrEn, trigWrData, lineLevel, ackValid, ackLine, reinit, maskReg} = v[45:16];
      @(negedge clk);
      check($sformatf("R1-7 vec%0d req", vi), reqMasked, v[15:8]);
      check($sformatf("R5 vec%0d trig", vi), trigMode, v[7:0]);
    end

    // Mask applies combinationally (R7): change mask without a clock edge.
    idleInputs();
    lineLevel = 8'h04;
    @(negedge clk);
    check("R2 rise line2", reqMasked, 8'h04);
    maskReg = 8'h04;
    #1;
    check("R7 comb mask", reqMasked, 8'h00);
    maskReg = 8'h00;
    #1;
    check("R7 comb unmask", reqMasked, 8'h04);

    // Held edge line: reinit then re-edge next cycle (R6).
    reinit = 1'b1;
    @(negedge clk);
    check("R6 reinit drop", reqMasked, 8'h00);
    reinit = 1'b0;
    @(negedge clk);
    check("R6 fresh edge", reqMasked, 8'h04);

    // Mid-run reset (R8).
    trigWrEn = 1'b1;
    trigWrData = 8'h08;
    @(negedge clk);
    trigWrEn = 1'b0;
    check("R5 set line3 level", trigMode, 8'h08);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 mid reset req", reqMasked, 8'h00);
    check("R8 mid reset trig", trigMode, 8'h00);
    idleInputs();
    rstN = 1'b1;
    @(negedge clk);
    check("R8 after reset", reqMasked, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule